// File: doc/BRIEF.md
# Register Renaming Map Unit

This block renames the architectural registers of one decoded instruction per cycle. For each instruction it looks up the physical registers that hold the two source operands. When the instruction writes a register, it hands that instruction a fresh physical register. The destination then no longer shares storage with earlier readers or writers of the same architectural register, so write-after-read and write-after-write conflicts disappear. Only true data dependences remain.

The unit holds an alias table, with one physical tag per architectural register, and a first-in first-out pool of unused physical tags. The source tags, the new destination tag and the destination's previous tag are all combinational from the current-cycle inputs. The table and the pool change at the next rising clock edge.

Once the instruction that overwrote a mapping retires, the previous tag can no longer be read. Retire logic then returns it through the return port, and it joins the back of the pool. Architectural register zero is tied to physical register zero and is never renamed. When the pool is empty and a destination is needed, the unit raises stall and changes nothing.

Top module: `rn_map_unit`

## Requirements
- R1: After reset, architectural register i maps to physical register i. The pool then holds physical registers 8 to 15 (with the default 8 architectural and 16 physical registers), in ascending order from its head.
- R2: The source tags `src_a_preg` and `src_b_preg` are the table entries of `src_a_lreg` and `src_b_lreg` in the same cycle.
- R3: An instruction that allocates takes the pool's head as `dst_preg`. From the next cycle, the table entry of `dst_lreg` holds that tag.
- R4: Tags leave the pool in the order they entered it. Successive allocations after reset receive 8, 9, 10 and so on.
- R5: A source that names the instruction's own destination reads the mapping from before that instruction's update.
- R6: Architectural register 0 always reads physical register 0. A write to it allocates nothing: `dst_preg` and `prev_preg` are 0 and the pool is untouched.
- R7: When a destination is needed and the pool is empty, `stall` is 1, `dst_preg` and `prev_preg` are 0, and neither the table nor the pool changes. Otherwise `stall` is 0.
- R8: When allocating, `prev_preg` is the mapping of `dst_lreg` before the update. Without an allocation it is 0.
- R9: An instruction with `dst_wen` low, or any cycle with `dec_valid` low, allocates nothing and leaves the table unchanged. In that case `dst_preg` is 0.
- R10: A tag presented with `ret_valid` joins the tail of the pool at the clock edge. It is handed out after every tag already in the pool. A return and an allocation may happen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| dec_valid | input | 1 | An instruction is presented for renaming |
| src_a_lreg | input | 3 | First source architectural register |
| src_b_lreg | input | 3 | Second source architectural register |
| dst_wen | input | 1 | The instruction writes a destination |
| dst_lreg | input | 3 | Destination architectural register |
| ret_valid | input | 1 | A retired tag is returned to the pool |
| ret_preg | input | 4 | Returned physical tag (never 0) |
| src_a_preg | output | 4 | Physical tag of the first source |
| src_b_preg | output | 4 | Physical tag of the second source |
| dst_preg | output | 4 | Newly allocated destination tag, 0 if none |
| prev_preg | output | 4 | Tag the destination replaced, 0 if none |
| stall | output | 1 | Pool empty while a destination is needed |

## Verification
The hardest state to reach is an empty pool that meets a renaming instruction while a return arrives nearby. From the ports, the only way to reach it is to spend all eight tags through real allocations. The stimulus table does exactly that and then presents one more writer, which must stall. It then returns a single freed tag and checks that the blocked writer receives that tag. A return and an allocation follow in the same cycle, so the pool is fed and drained at its one-entry boundary.

// File: rtl/rn_pkg.sv
// Package: shared constants and pointer helper for the rename unit.
// Assumes: consumers size their ports from these defaults or their own parameters.
package rn_pkg;
    localparam int RN_LOG_REGS  = 8;
    localparam int RN_PHYS_REGS = 16;

    // Advance a circular index, wrapping at depth-1.
    function automatic int unsigned rn_wrap_inc(input int unsigned idx, input int unsigned depth);
        return (idx == depth - 1) ? 0 : idx + 1;
    endfunction
endpackage

// File: rtl/rn_alias_table.sv
// Module: rn_alias_table
// Holds one physical tag per architectural register, with three combinational
// read ports and one write port. Assumes the caller never writes entry 0.
module rn_alias_table #(
    parameter int LOG_REGS  = 8,
    parameter int PHYS_REGS = 16,
    parameter int LW        = $clog2(LOG_REGS),
    parameter int PW        = $clog2(PHYS_REGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] rd_a_idx,
    input  logic [LW-1:0] rd_b_idx,
    input  logic [LW-1:0] rd_c_idx,
    output logic [PW-1:0] rd_a_tag,
    output logic [PW-1:0] rd_b_tag,
    output logic [PW-1:0] rd_c_tag,
    input  logic          wr_en,
    input  logic [LW-1:0] wr_idx,
    input  logic [PW-1:0] wr_tag
);
    logic [PW-1:0] entry_q [LOG_REGS];

    genvar gi;
    generate
        for (gi = 0; gi < LOG_REGS; gi++) begin : g_entry
            // Entry register: identity mapping at reset, replaced on a matching write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    entry_q[gi] <= PW'(gi);
                else if (wr_en && wr_idx == LW'(gi))
                    entry_q[gi] <= wr_tag;
            end
        end
    endgenerate

    // Read ports: current table contents, before this cycle's write.
    always_comb begin
        rd_a_tag = entry_q[rd_a_idx];
        rd_b_tag = entry_q[rd_b_idx];
        rd_c_tag = entry_q[rd_c_idx];
    end

    // R6
    zero_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entry_q[0] == '0);
    // R6
    zero_never_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_idx != '0);
    // R3
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> entry_q[$past(wr_idx)] == $past(wr_tag));
endmodule

// File: rtl/rn_free_pool.sv
// Module: rn_free_pool
// Circular FIFO of unused physical tags. At reset it holds LOG_REGS..PHYS_REGS-1
// in ascending order. Assumes the caller pops only when not empty and never
// pushes into a full pool.
module rn_free_pool
    import rn_pkg::*;
#(
    parameter int LOG_REGS  = 8,
    parameter int PHYS_REGS = 16,
    parameter int PW        = $clog2(PHYS_REGS),
    parameter int DEPTH     = PHYS_REGS,
    parameter int IW        = $clog2(DEPTH),
    parameter int CW        = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop,
    output logic [PW-1:0] head_tag,
    output logic          empty,
    input  logic          push,
    input  logic [PW-1:0] push_tag
);
    localparam int INIT_CNT = PHYS_REGS - LOG_REGS;

    logic [PW-1:0] slot_q [DEPTH];
    logic [IW-1:0] rd_ptr_q, wr_ptr_q;
    logic [CW-1:0] cnt_q;
    logic          full;

    // Status decode from the occupancy counter.
    always_comb begin
        empty    = (cnt_q == '0);
        full     = (cnt_q == CW'(DEPTH));
        head_tag = slot_q[rd_ptr_q];
    end

    // Slot storage: seeded with spare tags at reset, written at the tail on push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                slot_q[i] <= (i < INIT_CNT) ? PW'(LOG_REGS + i) : '0;
        end else if (push) begin
            slot_q[wr_ptr_q] <= push_tag;
        end
    end

    // Pointers and counter: move independently for push and pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr_q <= '0;
            wr_ptr_q <= IW'(INIT_CNT % DEPTH);
            cnt_q    <= CW'(INIT_CNT);
        end else begin
            if (pop)
                rd_ptr_q <= IW'(rn_wrap_inc(int'(rd_ptr_q), DEPTH));
            if (push)
                wr_ptr_q <= IW'(rn_wrap_inc(int'(wr_ptr_q), DEPTH));
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // R7
    pop_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> !full);
endmodule

// File: rtl/rn_map_unit.sv
// Module: rn_map_unit (top)
// Renames one instruction per cycle: source lookup, destination allocation
// from the free pool, table update, and return of retired tags.
// Assumes returned tags are nonzero and were previously handed out.
module rn_map_unit #(
    parameter int LOG_REGS  = rn_pkg::RN_LOG_REGS,
    parameter int PHYS_REGS = rn_pkg::RN_PHYS_REGS,
    parameter int LW        = $clog2(LOG_REGS),
    parameter int PW        = $clog2(PHYS_REGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dec_valid,
    input  logic [LW-1:0] src_a_lreg,
    input  logic [LW-1:0] src_b_lreg,
    input  logic          dst_wen,
    input  logic [LW-1:0] dst_lreg,
    input  logic          ret_valid,
    input  logic [PW-1:0] ret_preg,
    output logic [PW-1:0] src_a_preg,
    output logic [PW-1:0] src_b_preg,
    output logic [PW-1:0] dst_preg,
    output logic [PW-1:0] prev_preg,
    output logic          stall
);
    logic          needs_dst, alloc, pool_empty;
    logic [PW-1:0] pool_head, cur_dst_tag;

    // Decide whether this instruction takes a tag, or must wait.
    always_comb begin
        needs_dst  = dec_valid && dst_wen && (dst_lreg != '0);
        stall      = needs_dst && pool_empty;
        alloc      = needs_dst && !pool_empty;
        dst_preg   = alloc ? pool_head   : '0;
        prev_preg  = alloc ? cur_dst_tag : '0;
    end

    rn_alias_table #(
        .LOG_REGS (LOG_REGS),
        .PHYS_REGS(PHYS_REGS),
        .LW       (LW),
        .PW       (PW)
    ) table_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_a_idx(src_a_lreg),
        .rd_b_idx(src_b_lreg),
        .rd_c_idx(dst_lreg),
        .rd_a_tag(src_a_preg),
        .rd_b_tag(src_b_preg),
        .rd_c_tag(cur_dst_tag),
        .wr_en   (alloc),
        .wr_idx  (dst_lreg),
        .wr_tag  (pool_head)
    );

    rn_free_pool #(
        .LOG_REGS (LOG_REGS),
        .PHYS_REGS(PHYS_REGS),
        .PW       (PW)
    ) pool_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .pop     (alloc),
        .head_tag(pool_head),
        .empty   (pool_empty),
        .push    (ret_valid),
        .push_tag(ret_preg)
    );

    // R8
    fresh_differs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> dst_preg != prev_preg);
    // R10
    return_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> ret_preg != '0);
endmodule

// File: tb/rn_map_unit_tb.sv
// Bench: a stimulus/expectation table walked in one loop, then directed reset
// and corner-case tests. Inputs change at the falling edge; outputs are sampled
// 2 ns later, before the next rising edge.
module rn_map_unit_tb_top;
    typedef struct packed {
        logic       v;
        logic [2:0] sa;
        logic [2:0] sb;
        logic       we;
        logic [2:0] d;
        logic       rv;
        logic [3:0] rp;
        logic [3:0] ea;
        logic [3:0] eb;
        logic [3:0] ed;
        logic [3:0] eo;
        logic       es;
    } vec_t;

    // Sequence from reset: table i->i, pool 8..15.
    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 3'd3, 3'd3, 1'b1, 3'd3, 1'b0, 4'd0,  4'd3,  4'd3,  4'd8,  4'd3,  1'b0}, // R5 R4
        '{1'b1, 3'd3, 3'd1, 1'b1, 3'd1, 1'b0, 4'd0,  4'd8,  4'd1,  4'd9,  4'd1,  1'b0}, // R3
        '{1'b1, 3'd1, 3'd2, 1'b1, 3'd3, 1'b0, 4'd0,  4'd9,  4'd2,  4'd10, 4'd8,  1'b0}, // R8
        '{1'b1, 3'd3, 3'd1, 1'b0, 3'd5, 1'b0, 4'd0,  4'd10, 4'd9,  4'd0,  4'd0,  1'b0}, // R9
        '{1'b1, 3'd0, 3'd5, 1'b1, 3'd0, 1'b0, 4'd0,  4'd0,  4'd5,  4'd0,  4'd0,  1'b0}, // R6
        '{1'b1, 3'd5, 3'd3, 1'b1, 3'd5, 1'b0, 4'd0,  4'd5,  4'd10, 4'd11, 4'd5,  1'b0}, // R9 R6
        '{1'b1, 3'd2, 3'd5, 1'b1, 3'd2, 1'b0, 4'd0,  4'd2,  4'd11, 4'd12, 4'd2,  1'b0}, // R2
        '{1'b1, 3'd4, 3'd2, 1'b1, 3'd4, 1'b0, 4'd0,  4'd4,  4'd12, 4'd13, 4'd4,  1'b0},
        '{1'b1, 3'd6, 3'd0, 1'b1, 3'd6, 1'b0, 4'd0,  4'd6,  4'd0,  4'd14, 4'd6,  1'b0},
        '{1'b1, 3'd7, 3'd3, 1'b1, 3'd7, 1'b0, 4'd0,  4'd7,  4'd10, 4'd15, 4'd7,  1'b0},
        '{1'b1, 3'd1, 3'd1, 1'b1, 3'd1, 1'b0, 4'd0,  4'd9,  4'd9,  4'd0,  4'd0,  1'b1}, // R7
        '{1'b0, 3'd1, 3'd7, 1'b1, 3'd1, 1'b1, 4'd3,  4'd9,  4'd15, 4'd0,  4'd0,  1'b0}, // R7 R10
        '{1'b1, 3'd1, 3'd3, 1'b1, 3'd1, 1'b1, 4'd8,  4'd9,  4'd10, 4'd3,  4'd9,  1'b0}, // R10
        '{1'b1, 3'd1, 3'd2, 1'b1, 3'd2, 1'b0, 4'd0,  4'd3,  4'd12, 4'd8,  4'd12, 1'b0}  // R10
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       dec_valid, dst_wen, ret_valid;
    logic [2:0] src_a_lreg, src_b_lreg, dst_lreg;
    logic [3:0] ret_preg;
    logic [3:0] src_a_preg, src_b_preg, dst_preg, prev_preg;
    logic       stall;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    rn_map_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .dec_valid (dec_valid),
        .src_a_lreg(src_a_lreg),
        .src_b_lreg(src_b_lreg),
        .dst_wen   (dst_wen),
        .dst_lreg  (dst_lreg),
        .ret_valid (ret_valid),
        .ret_preg  (ret_preg),
        .src_a_preg(src_a_preg),
        .src_b_preg(src_b_preg),
        .dst_preg  (dst_preg),
        .prev_preg (prev_preg),
        .stall     (stall)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [2:0] sa, input logic [2:0] sb,
                         input logic we, input logic [2:0] d,
                         input logic rv, input logic [3:0] rp);
        @(negedge clk);
        dec_valid = v; src_a_lreg = sa; src_b_lreg = sb;
        dst_wen = we; dst_lreg = d; ret_valid = rv; ret_preg = rp;
        #2;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        dec_valid = 0; dst_wen = 0; ret_valid = 0;
        src_a_lreg = 0; src_b_lreg = 0; dst_lreg = 0; ret_preg = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();

        // R1: identity mapping after reset, read through the source ports.
        for (int i = 0; i < 8; i += 2) begin
            drive(1'b0, 3'(i), 3'(i + 1), 1'b0, 3'd0, 1'b0, 4'd0);
            check("R1", "src_a", int'(src_a_preg), i);
            check("R1", "src_b", int'(src_b_preg), i + 1);
            check("R1", "stall", int'(stall), 0);
        end

        // Table walk (R2..R10).
        for (int k = 0; k < NV; k++) begin
            drive(VECS[k].v, VECS[k].sa, VECS[k].sb, VECS[k].we, VECS[k].d,
                  VECS[k].rv, VECS[k].rp);
            check("R2", $sformatf("vec%0d src_a", k), int'(src_a_preg), int'(VECS[k].ea));
            check("R2", $sformatf("vec%0d src_b", k), int'(src_b_preg), int'(VECS[k].eb));
            check("R3", $sformatf("vec%0d dst", k), int'(dst_preg), int'(VECS[k].ed));
            check("R8", $sformatf("vec%0d prev", k), int'(prev_preg), int'(VECS[k].eo));
            check("R7", $sformatf("vec%0d stall", k), int'(stall), int'(VECS[k].es));
        end

        // R1 R4: after a reset mid-run, the pool restarts at 8 in ascending order.
        do_reset();
        for (int j = 1; j < 4; j++) begin
            drive(1'b1, 3'(j), 3'd0, 1'b1, 3'(j), 1'b0, 4'd0);
            check("R4", "alloc order", int'(dst_preg), 7 + j);
            check("R1", "prev identity", int'(prev_preg), j);
        end

        // R9: a write request without dec_valid changes neither table nor pool.
        drive(1'b0, 3'd5, 3'd0, 1'b1, 3'd5, 1'b0, 4'd0);
        check("R9", "dst without valid", int'(dst_preg), 0);
        drive(1'b1, 3'd5, 3'd0, 1'b1, 3'd5, 1'b0, 4'd0);
        check("R9", "table unchanged", int'(src_a_preg), 5);
        check("R9", "pool unchanged", int'(dst_preg), 11);

        // R6: r0 source always reads tag 0 even after writes aimed at it.
        drive(1'b1, 3'd0, 3'd0, 1'b1, 3'd0, 1'b0, 4'd0);
        check("R6", "r0 dst", int'(dst_preg), 0);
        drive(1'b1, 3'd0, 3'd5, 1'b0, 3'd0, 1'b0, 4'd0);
        check("R6", "r0 src", int'(src_a_preg), 0);
        check("R3", "r5 renamed", int'(src_b_preg), 11);

        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule